// File: doc/BRIEF.md
# SPI Serial Slave Front End

This block is the bus-facing front end of a serial memory device. It samples the serial clock, serial data input, active-low chip select and active-low hold pins in a fast system clock domain, and assembles incoming bits into bytes. Each completed byte is handed to the command logic with a one-cycle strobe. Outgoing bytes are taken from the command logic and shifted out on the serial data output, together with an output-enable that a pad or tristate driver uses.

The bus master may idle its clock low or high. No configuration input selects between the two. Bits are sampled on rising clock edges and launched after falling edges in both cases. After reset the block stays deaf until it sees chip select fall. A hold pause stops the transfer while the device stays selected, and a deselect ends the frame and tells the command logic so.

Top module: `spi_slave_fe`

## Requirements
- R1: Transfers work with the serial clock idling low (mode 0) or idling high (mode 3), with no configuration input, and give identical received and transmitted data in both.
- R2: Serial input is sampled on each rising serial clock edge, most significant bit first; after the eighth rising edge of a byte, rx_byte_o holds the assembled byte.
- R3: The transmit bit on so_o changes only in response to a falling serial clock edge or a chip select fall. Bits go out most significant bit first, and bit 7 of the first byte appears from the moment of selection.
- R4: tx_byte_i is sampled when chip select falls and again at the first falling serial clock edge after each completed byte; that value provides the next byte sent.
- R5: While chip select is high, so_oe_o is low and serial clock edges have no effect on the received data.
- R6: After reset, until a chip select falling edge has been seen, rx_valid_o and frame_end_o stay low and so_oe_o stays low, even if clock pulses arrive with chip select already low.
- R7: While selected, hold begins when hold_n_i and the serial clock are both low, and ends when hold_n_i is high while the serial clock is low. During hold, so_oe_o is low, clock and data edges are ignored, and the bit count and both shift registers keep their values, so the byte resumes correctly afterwards.
- R8: rx_valid_o is a single-cycle pulse, raised exactly once per eight received bits.
- R9: A chip select rising edge after arming clears the bit count, discards a partial byte, and raises frame_end_o for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the bus master |
| si_i | input | 1 | Serial data into the device |
| cs_n_i | input | 1 | Active-low chip select |
| hold_n_i | input | 1 | Active-low hold request |
| tx_byte_i | input | DATA_W | Next byte to shift out, from the command logic |
| so_o | output | 1 | Serial data out of the device |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |
| rx_byte_o | output | DATA_W | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe when rx_byte_o is updated |
| frame_end_o | output | 1 | One-cycle pulse when chip select rises |

## Verification
The bench runs the same two-byte exchange in both clock idle levels. In mode 3 the first falling edge comes before any data. A design that shifted on it would lose bit 7 of the outgoing byte. A design held in reset with chip select already low is clocked, and one that skipped the arming rule would strobe a byte. A three-bit fragment followed by a fresh frame shows whether a deselect really drops a partial byte; a leftover bit count would misalign the next byte. A hold in the middle of a byte, with the clock and data toggled during the hold, tests whether the shift state is frozen; a design that is not frozen would corrupt both directions of that byte.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
   localparam int PIN_N    = 4;
   localparam int PIN_SCK  = 0;
   localparam int PIN_SI   = 1;
   localparam int PIN_CS   = 2;
   localparam int PIN_HOLD = 3;
   // synchronizer reset levels: chip select resets low so that a select held
   // across reset never shows a falling edge; hold resets inactive
   localparam logic [PIN_N-1:0] PIN_RST = 4'b1000;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int             W      = 4,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_fe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= RST;
         else if (s == 0) stg[s] <= d;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
   parameter int           W   = 4,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= RST;
      else        lvl_d <= lvl;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign rise[i] =  lvl[i] & ~lvl_d[i];
      assign fall[i] = ~lvl[i] &  lvl_d[i];
   end
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic hold_s,
   input  logic cs_s,
   input  logic sck_rise,
   input  logic sck_fall,
   input  logic cs_rise,
   input  logic cs_fall,
   output logic armed,
   output logic hold_act,
   output logic sck_rise_g,
   output logic sck_fall_g,
   output logic frame_clr,
   output logic frame_end,
   output logic so_oe
);
   logic active;
   logic hold_nxt;

   assign active     = armed & ~cs_s;
   assign sck_rise_g = sck_rise & active & ~hold_act;
   assign sck_fall_g = sck_fall & active & ~hold_act;
   assign frame_clr  = cs_rise & armed;

   always_comb begin
      hold_nxt = hold_act;
      if (!active)        hold_nxt = 1'b0;
      else if (!hold_act) hold_nxt = ~hold_s & ~sck_s;
      else if (hold_s && !sck_s) hold_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         hold_act  <= 1'b0;
         frame_end <= 1'b0;
         so_oe     <= 1'b0;
      end else begin
         if (cs_fall) armed <= 1'b1;
         hold_act  <= hold_nxt;
         frame_end <= frame_clr;
         so_oe     <= active & ~hold_act;
      end
   end
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              si_s,
   input  logic              sck_rise_g,
   input  logic              sck_fall_g,
   input  logic              cs_fall,
   input  logic              frame_clr,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              so_bit,
   output logic [CNT_W-1:0]  bit_cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W-1);

   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_nxt;
   logic              need_shift;
   logic              byte_done;

   assign rx_nxt = {rx_sh[DATA_W-2:0], si_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh      <= '0;
         tx_sh      <= '0;
         rx_byte    <= '0;
         rx_valid   <= 1'b0;
         so_bit     <= 1'b0;
         bit_cnt    <= '0;
         need_shift <= 1'b0;
         byte_done  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (cs_fall || frame_clr) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            need_shift <= 1'b0;
            byte_done  <= 1'b0;
            if (cs_fall) begin
               so_bit <= tx_byte[DATA_W-1];
               tx_sh  <= tx_byte << 1;
            end
         end else if (sck_rise_g) begin
            rx_sh      <= rx_nxt;
            need_shift <= 1'b1;
            if (bit_cnt == LAST) begin
               rx_byte   <= rx_nxt;
               rx_valid  <= 1'b1;
               bit_cnt   <= '0;
               byte_done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else if (sck_fall_g && need_shift) begin
            need_shift <= 1'b0;
            byte_done  <= 1'b0;
            if (byte_done) begin
               so_bit <= tx_byte[DATA_W-1];
               tx_sh  <= tx_byte << 1;
            end else begin
               so_bit <= tx_sh[DATA_W-1];
               tx_sh  <= tx_sh << 1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_slave_fe.sv
module spi_slave_fe
   import spi_fe_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_i,
   input  logic              si_i,
   input  logic              cs_n_i,
   input  logic              hold_n_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic              so_o,
   output logic              so_oe_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              rx_valid_o,
   output logic              frame_end_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("spi_slave_fe: DATA_W must be at least 2");
   end

   logic [PIN_N-1:0] pins_raw, pins_s, pins_rise, pins_fall;
   logic             armed, hold_act, sck_rise_g, sck_fall_g, frame_clr;
   logic [CNT_W-1:0] bit_cnt;

   assign pins_raw[PIN_SCK]  = sck_i;
   assign pins_raw[PIN_SI]   = si_i;
   assign pins_raw[PIN_CS]   = cs_n_i;
   assign pins_raw[PIN_HOLD] = hold_n_i;

   spi_fe_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
   );

   spi_fe_edge #(.W(PIN_N), .RST(PIN_RST)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pins_s), .rise(pins_rise), .fall(pins_fall)
   );

   spi_fe_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sck_s(pins_s[PIN_SCK]), .hold_s(pins_s[PIN_HOLD]), .cs_s(pins_s[PIN_CS]),
      .sck_rise(pins_rise[PIN_SCK]), .sck_fall(pins_fall[PIN_SCK]),
      .cs_rise(pins_rise[PIN_CS]), .cs_fall(pins_fall[PIN_CS]),
      .armed(armed), .hold_act(hold_act),
      .sck_rise_g(sck_rise_g), .sck_fall_g(sck_fall_g),
      .frame_clr(frame_clr), .frame_end(frame_end_o), .so_oe(so_oe_o)
   );

   spi_fe_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .si_s(pins_s[PIN_SI]),
      .sck_rise_g(sck_rise_g), .sck_fall_g(sck_fall_g),
      .cs_fall(pins_fall[PIN_CS]), .frame_clr(frame_clr),
      .tx_byte(tx_byte_i), .rx_byte(rx_byte_o), .rx_valid(rx_valid_o),
      .so_bit(so_o), .bit_cnt(bit_cnt)
   );

   logic unused_ok;
   assign unused_ok = &{1'b0, pins_rise[PIN_SI], pins_fall[PIN_SI],
                        pins_rise[PIN_HOLD], pins_fall[PIN_HOLD]};
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             so_o,
   input logic             so_oe_o,
   input logic             rx_valid_o,
   input logic             frame_end_o,
   input logic             cs_s,
   input logic             cs_fall,
   input logic             armed,
   input logic             hold_act,
   input logic             sck_fall_g,
   input logic [CNT_W-1:0] bit_cnt
);
   assert_oe_off_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_s) |-> !so_oe_o);

   assert_oe_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_act) |-> !so_oe_o);

   assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act && $past(hold_act)) |-> $stable(bit_cnt));

   assert_quiet_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(armed) |-> (!rx_valid_o && !frame_end_o && !so_oe_o));

   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   assert_frame_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |=> !frame_end_o);

   assert_so_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (so_o != $past(so_o)) |-> $past(sck_fall_g || cs_fall));
endmodule

bind spi_slave_fe spi_fe_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .so_o(so_o), .so_oe_o(so_oe_o),
   .rx_valid_o(rx_valid_o), .frame_end_o(frame_end_o),
   .cs_s(pins_s[spi_fe_pkg::PIN_CS]), .cs_fall(pins_fall[spi_fe_pkg::PIN_CS]),
   .armed(armed), .hold_act(hold_act), .sck_fall_g(sck_fall_g), .bit_cnt(bit_cnt)
);

// File: tb/spi_slave_fe_bench.sv
`timescale 1ns/1ps
module spi_slave_fe_bench;
   localparam int HALF = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
   logic [7:0] tx_byte = 8'h00;
   logic       so, so_oe, rx_valid, frame_end;
   logic [7:0] rx_byte;

   int checks = 0, fails = 0;
   int vcnt = 0, fcnt = 0;
   logic [7:0] last_rx = 8'h00;
   logic idle_lvl = 1'b0;

   always #5 clk = ~clk;

   spi_slave_fe u_spi_slave_fe (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .cs_n_i(cs_n),
      .hold_n_i(hold_n), .tx_byte_i(tx_byte), .so_o(so), .so_oe_o(so_oe),
      .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .frame_end_o(frame_end)
   );

   always @(negedge clk) begin
      if (rx_valid) begin vcnt++; last_rx = rx_byte; end
      if (frame_end) fcnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_half();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic sck_set(input logic v);
      sck = v;
      wait_half();
   endtask

   task automatic select();
      sck = idle_lvl;
      wait_half();
      cs_n = 1'b0;
      wait_half();
   endtask

   task automatic deselect();
      sck_set(idle_lvl);
      cs_n = 1'b1;
      wait_half();
   endtask

   task automatic xfer_bits(input logic [7:0] mosi, input int hi, input int lo,
                            inout logic [7:0] miso);
      for (int i = hi; i >= lo; i--) begin
         sck_set(1'b0);
         si = mosi[i];
         miso[i] = so;
         sck_set(1'b1);
      end
   endtask

   task automatic do_reset(input logic cs_level);
      rst_n = 1'b0;
      cs_n = cs_level;
      sck = 1'b0; hold_n = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk(so_oe == 1'b0, "R5 reset oe", so_oe, 0);
      chk(rx_valid == 1'b0 && frame_end == 1'b0, "R6 reset strobes",
          {rx_valid, frame_end}, 0);
   endtask

   // R6: select held across reset never arms the block
   task automatic t_unarmed();
      logic [7:0] m;
      int v0, f0;
      do_reset(1'b0);
      v0 = vcnt; f0 = fcnt;
      m = 8'h00;
      xfer_bits(8'hFF, 7, 0, m);
      sck_set(1'b0);
      chk(vcnt == v0, "R6 no byte before arming", vcnt - v0, 0);
      chk(so_oe == 1'b0, "R6 oe low before arming", so_oe, 0);
      cs_n = 1'b1;
      wait_half();
      chk(fcnt == f0, "R6 no frame end before arming", fcnt - f0, 0);
   endtask

   task automatic t_two_bytes(input logic mode3, input logic [7:0] a, input logic [7:0] b,
                              input logic [7:0] ta, input logic [7:0] tb);
      logic [7:0] m0, m1;
      int v0, f0;
      idle_lvl = mode3;
      v0 = vcnt; f0 = fcnt;
      tx_byte = ta;
      select();
      chk(so_oe == 1'b1, "R1 oe on after select", so_oe, 1);
      chk(so == ta[7], "R3 first bit at select", so, ta[7]);
      m0 = 8'h00; m1 = 8'h00;
      xfer_bits(a, 7, 0, m0);
      chk(last_rx == a, "R2 first rx byte", last_rx, a);
      tx_byte = tb;
      xfer_bits(b, 7, 0, m1);
      chk(last_rx == b, "R2 second rx byte", last_rx, b);
      chk(vcnt - v0 == 2, "R8 one strobe per byte", vcnt - v0, 2);
      chk(m0 == ta, "R3 first tx byte", m0, ta);
      chk(m1 == tb, "R4 second tx byte", m1, tb);
      deselect();
      chk(fcnt - f0 == 1, "R9 frame end pulse", fcnt - f0, 1);
      chk(so_oe == 1'b0, "R5 oe off after deselect", so_oe, 0);
   endtask

   // R5: clock pulses while deselected do nothing
   task automatic t_deselected_clocks();
      logic [7:0] m;
      int v0;
      v0 = vcnt;
      m = 8'h00;
      xfer_bits(8'h5A, 7, 0, m);
      sck_set(1'b0);
      chk(vcnt == v0, "R5 no byte while deselected", vcnt - v0, 0);
      chk(so_oe == 1'b0, "R5 oe low while deselected", so_oe, 0);
   endtask

   // R9: a partial byte is dropped at deselect
   task automatic t_partial();
      logic [7:0] m;
      int v0;
      idle_lvl = 1'b0;
      v0 = vcnt;
      tx_byte = 8'h00;
      select();
      m = 8'h00;
      xfer_bits(8'hE0, 7, 5, m);
      deselect();
      chk(vcnt == v0, "R9 partial byte dropped", vcnt - v0, 0);
      select();
      xfer_bits(8'h81, 7, 0, m);
      chk(vcnt - v0 == 1 && last_rx == 8'h81, "R9 clean restart", last_rx, 8'h81);
      deselect();
   endtask

   // R7: hold in the middle of a byte
   task automatic t_hold();
      logic [7:0] m;
      int v0;
      idle_lvl = 1'b0;
      v0 = vcnt;
      tx_byte = 8'hB2;
      select();
      m = 8'h00;
      xfer_bits(8'hC9, 7, 4, m);
      sck_set(1'b0);
      hold_n = 1'b0;
      wait_half();
      chk(so_oe == 1'b0, "R7 oe off during hold", so_oe, 0);
      for (int k = 0; k < 3; k++) begin
         si = k[0];
         sck_set(1'b1);
         sck_set(1'b0);
      end
      chk(vcnt == v0, "R7 clocks ignored in hold", vcnt - v0, 0);
      hold_n = 1'b1;
      wait_half();
      chk(so_oe == 1'b1, "R7 oe back after hold", so_oe, 1);
      xfer_bits(8'hC9, 3, 0, m);
      chk(vcnt - v0 == 1 && last_rx == 8'hC9, "R7 rx resumes", last_rx, 8'hC9);
      chk(m == 8'hB2, "R7 tx resumes", m, 8'hB2);
      deselect();
   endtask

   initial begin
      do_reset(1'b1);
      t_reset_state();
      t_unarmed();
      do_reset(1'b1);
      t_two_bytes(1'b0, 8'hA5, 8'h3C, 8'h96, 8'hC3);
      t_two_bytes(1'b1, 8'h71, 8'h0E, 8'h4D, 8'hF0);
      t_deselected_clocks();
      t_partial();
      t_hold();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule